// File: doc/BRIEF.md
# Parallel I/O Port with Edge-Capture Interrupt

This block is a general-purpose parallel I/O peripheral that sits on a simple word-addressed register bus. The bus has separate read and write strobes, and read data arrives one cycle after the read strobe. Each pin has an output value, an output-enable bit and an input path. The input path passes the pin through a two-flop synchronizer before the block uses it.

The synchronized inputs feed an edge detector. A build parameter sets the edge type to rising or falling. Each detected edge sets a sticky per-bit capture flag. A mask register selects which flags may drive the single level interrupt line. Software services an interrupt by reading the capture register and then writing to it, which clears it. An optional pair of write-only offsets can set or clear individual output bits without a read-modify-write.

Top module: `gpioEdge`

## Requirements
- R1: While rstN is low, and after its release until the first write, pinOut, pinOe, irq, rdData and every register read as 0.
- R2: A write to offset 0 loads pinOut with wrData on the next clock edge. A write to offset 1 loads pinOe on the next clock edge. A read of offset 1 returns the current pinOe value.
- R3: rdData changes only at the clock edge that samples rdEn high, and it holds its value while rdEn is low. Reads of offsets 4, 5, 6 and 7 return 0.
- R4: A read of offset 0 returns pinIn as it was two cycles before the cycle in which rdEn is high.
- R5: With EDGE_RISING = 0, bit i of the capture register (offset 3) becomes 1 when synchronized input bit i goes from 1 to 0. A 0-to-1 change, or no change, does not set the bit. With EDGE_RISING = 1 the polarity is reversed.
- R6: A capture bit stays 1 until the register is cleared. Any write to offset 3 clears every capture bit, whatever the write data. A bit whose edge is detected in the same cycle as the clearing write stays 1.
- R7: irq is 1 exactly when some bit is 1 in both the capture register and the mask register (offset 2). A mask bit of 1 enables its input.
- R8: With SET_CLR_EN = 1, a write to offset 4 ORs wrData into pinOut and a write to offset 5 clears the pinOut bits where wrData is 1. Zero bits leave pinOut unchanged.
- R9: With SET_CLR_EN = 0, writes to offsets 4 and 5 leave pinOut unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word offset of the access |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | WIDTH | Write data |
| rdData | output | WIDTH | Read data, valid the cycle after rdEn |
| pinIn | input | WIDTH | Asynchronous pin inputs |
| pinOut | output | WIDTH | Pin output values |
| pinOe | output | WIDTH | Per-pin output enable |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that wrEn and rdEn are never high in the same cycle. The bench drives the two strobes from separate tasks, each of which raises its strobe for exactly one cycle. The check that a clearing write drops irq assumes pinIn has held steady long enough that no edge can reach the detector in that cycle, and a counter of cycles since reset limits that check to cycles after the synchronizer has filled. The stimulus lets the pins settle for several cycles before every clearing write, except in the one test that aims an edge at the clearing cycle on purpose.

// File: rtl/gpioEdgePkg.sv
package gpioEdgePkg;

  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_CAP  = 3'd3,
    SEL_ZERO = 3'd4
  } rdSelT;

  typedef struct packed {
    logic  wrOut;
    logic  wrDir;
    logic  wrMask;
    logic  clrCap;
    logic  wrSet;
    logic  wrClr;
    logic  rdEn;
    rdSelT rdSel;
  } gpioStrobeT;

  localparam int OFF_DATA = 0;
  localparam int OFF_DIR  = 1;
  localparam int OFF_MASK = 2;
  localparam int OFF_CAP  = 3;
  localparam int OFF_SET  = 4;
  localparam int OFF_CLR  = 5;

endpackage

// File: rtl/gpioEdgeSync.sv
module gpioEdgeSync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_W-WIDTH-1:0], asyncIn};
  end

  assign syncOut = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/gpioEdgeCtrl.sv
module gpioEdgeCtrl
  import gpioEdgePkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter bit SET_CLR_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output gpioStrobeT        strb
);
  logic [31:0] offset;
  assign offset = 32'(addr);

  always_comb begin
    strb       = '0;
    strb.rdEn  = rdEn;
    strb.rdSel = SEL_ZERO;
    case (offset)
      OFF_DATA: begin strb.wrOut  = wrEn; strb.rdSel = SEL_DATA; end
      OFF_DIR:  begin strb.wrDir  = wrEn; strb.rdSel = SEL_DIR;  end
      OFF_MASK: begin strb.wrMask = wrEn; strb.rdSel = SEL_MASK; end
      OFF_CAP:  begin strb.clrCap = wrEn; strb.rdSel = SEL_CAP;  end
      OFF_SET:  strb.wrSet = wrEn & SET_CLR_EN;
      OFF_CLR:  strb.wrClr = wrEn & SET_CLR_EN;
      default:  ;
    endcase
  end
endmodule

// File: rtl/gpioEdgeDp.sv
module gpioEdgeDp
  import gpioEdgePkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit EDGE_RISING = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStrobeT       strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic             irq
);
  logic [WIDTH-1:0] syncIn, prevIn, edgeHit;
  logic [WIDTH-1:0] outReg, dirReg, maskReg, capReg;

  gpioEdgeSync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncIn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn;
  end

  if (EDGE_RISING) begin : g_rise
    assign edgeHit = syncIn & ~prevIn;
  end else begin : g_fall
    assign edgeHit = ~syncIn & prevIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      dirReg  <= '0;
      maskReg <= '0;
      capReg  <= '0;
    end else begin
      if (strb.wrOut)      outReg <= wrData;
      else if (strb.wrSet) outReg <= outReg | wrData;
      else if (strb.wrClr) outReg <= outReg & ~wrData;
      if (strb.wrDir)  dirReg  <= wrData;
      if (strb.wrMask) maskReg <= wrData;
      capReg <= strb.clrCap ? edgeHit : (capReg | edgeHit);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdEn) begin
      case (strb.rdSel)
        SEL_DATA: rdData <= syncIn;
        SEL_DIR:  rdData <= dirReg;
        SEL_MASK: rdData <= maskReg;
        SEL_CAP:  rdData <= capReg;
        default:  rdData <= '0;
      endcase
    end
  end

  assign pinOut = outReg;
  assign pinOe  = dirReg;
  assign irq    = |(capReg & maskReg);
endmodule

// File: rtl/gpioEdge.sv
module gpioEdge
  import gpioEdgePkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 3,
  parameter bit EDGE_RISING = 1'b0,
  parameter bit SET_CLR_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  output logic              irq
);
  gpioStrobeT strb;

  gpioEdgeCtrl #(.ADDR_W(ADDR_W), .SET_CLR_EN(SET_CLR_EN)) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .strb(strb)
  );

  gpioEdgeDp #(.WIDTH(WIDTH), .EDGE_RISING(EDGE_RISING)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .pinIn(pinIn),
    .rdData(rdData), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );
endmodule

// File: rtl/gpioEdgeChk.sv
module gpioEdgeChk #(
  parameter int WIDTH      = 8,
  parameter int ADDR_W     = 3,
  parameter bit SET_CLR_EN = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [WIDTH-1:0]  wrData,
  input logic [WIDTH-1:0]  rdData,
  input logic [WIDTH-1:0]  pinIn,
  input logic [WIDTH-1:0]  pinOut,
  input logic [WIDTH-1:0]  pinOe,
  input logic              irq
);
  logic [31:0] off;
  logic [2:0]  sinceReset;
  assign off = 32'(addr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceReset <= '0;
    else if (sinceReset != 3'd7) sinceReset <= sinceReset + 3'd1;
  end

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && off == 0) |=> pinOut == $past(wrData)); // R2
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && off == 1) |=> pinOe == $past(wrData)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R3
  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && off >= 4) |=> rdData == '0); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrEn && (off == 2 || off == 3))) |=> irq); // R6
  AST_CLEAR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && off == 3 && sinceReset >= 3'd4 && $past(pinIn, 2) == $past(pinIn, 3))
    |=> !irq); // R6
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && off == 2 && wrData == '0) |=> !irq); // R7

  if (SET_CLR_EN) begin : g_sc
    AST_SET_OR: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && off == 4) |=> pinOut == ($past(pinOut) | $past(wrData))); // R8
    AST_CLR_AND: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && off == 5) |=> pinOut == ($past(pinOut) & ~$past(wrData))); // R8
  end else begin : g_nosc
    AST_SC_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && (off == 4 || off == 5)) |=> $stable(pinOut)); // R9
  end
endmodule

bind gpioEdge gpioEdgeChk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .SET_CLR_EN(SET_CLR_EN)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
  .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
);

// File: tb/gpioEdge_tb.sv
`timescale 1ns/1ps
module gpioEdge_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] wrData = '0, pinIn = '0;
  logic [3:0] rdData, pinOut, pinOe, rdData2, pinOut2, pinOe2;
  logic       irq, irq2;
  int vectors = 0, errors = 0;

  always #4 clk = ~clk;

  gpioEdge #(.WIDTH(4), .ADDR_W(3), .EDGE_RISING(1'b0), .SET_CLR_EN(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  gpioEdge #(.WIDTH(4), .ADDR_W(3), .EDGE_RISING(1'b0), .SET_CLR_EN(1'b0)) u_dutNoSc (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData2), .pinIn(pinIn), .pinOut(pinOut2), .pinOe(pinOe2), .irq(irq2)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] d);
    @(negedge clk); addr = 3'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [3:0] q);
    @(negedge clk); addr = 3'(a); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; q = rdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] q, hold;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 pinOut", pinOut, 4'h0);
    check("R1 pinOe", pinOe, 4'h0);
    check("R1 irq", {3'b0, irq}, 4'h0);
    check("R1 rdData", rdData, 4'h0);
    rstN = 1'b1;
    settle();
    for (int a = 0; a < 4; a++) begin
      rd(a, q); check("R1 register", q, 4'h0);
    end

    // R2 data and direction
    for (int d = 0; d < 16; d++) begin
      wr(0, 4'(d)); check("R2 pinOut", pinOut, 4'(d));
      wr(1, 4'(d) ^ 4'hA); check("R2 pinOe", pinOe, 4'(d) ^ 4'hA);
      rd(1, q); check("R2 dir read", q, 4'(d) ^ 4'hA);
    end

    // R4 synchronized input read latency
    for (int v = 0; v < 16; v++) begin
      hold = pinIn;
      @(negedge clk); pinIn = 4'(v);
      rd(0, q); check("R4 early read", q, hold);
      rd(0, q); check("R4 read", q, 4'(v));
    end

    // R3 unused offsets and hold
    wr(2, 4'h0);
    for (int a = 4; a < 8; a++) begin
      rd(a, q); check("R3 zero offset", q, 4'h0);
    end
    rd(1, q);
    hold = rdData;
    @(negedge clk); pinIn = ~pinIn;
    repeat (5) @(negedge clk);
    check("R3 hold", rdData, hold);

    // R5 and R7 edge capture sweep, falling edges, mask all ones
    wr(2, 4'hF);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk); pinIn = 4'(a);
        settle();
        wr(3, 4'h5);
        @(negedge clk); pinIn = 4'(b);
        settle();
        rd(3, q); check("R5 capture", q, 4'(a) & ~4'(b));
        check("R7 irq", {3'b0, irq}, {3'b0, |(4'(a) & ~4'(b))});
      end
    end

    // R7 mask sweep
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); pinIn = 4'hF;
      settle();
      wr(3, 4'h0);
      @(negedge clk); pinIn = ~4'(c);
      settle();
      for (int m = 0; m < 16; m++) begin
        wr(2, 4'(m));
        check("R7 masked irq", {3'b0, irq}, {3'b0, |(4'(c) & 4'(m))});
      end
    end

    // R6 sticky, clear, and edge winning over clear
    wr(2, 4'hF);
    @(negedge clk); pinIn = 4'hF;
    settle();
    wr(3, 4'h0);
    @(negedge clk); pinIn = 4'hE;
    settle();
    @(negedge clk); pinIn = 4'hF;
    settle();
    rd(3, q); check("R6 sticky", q, 4'h1);
    check("R6 sticky irq", {3'b0, irq}, 4'h1);
    @(negedge clk); pinIn = 4'hB;
    @(negedge clk);
    wr(3, 4'hF);
    rd(3, q); check("R6 edge wins", q, 4'h4);
    settle();
    wr(3, 4'h0);
    rd(3, q); check("R6 cleared", q, 4'h0);
    check("R6 irq low", {3'b0, irq}, 4'h0);

    // R8 set and clear offsets
    for (int o = 0; o < 16; o++) begin
      for (int s = 0; s < 16; s++) begin
        wr(0, 4'(o)); wr(4, 4'(s));
        check("R8 set", pinOut, 4'(o) | 4'(s));
        wr(0, 4'(o)); wr(5, 4'(s));
        check("R8 clear", pinOut, 4'(o) & ~4'(s));
      end
    end

    // R9 set and clear ignored when disabled
    for (int s = 0; s < 16; s++) begin
      wr(0, 4'h5);
      wr(4, 4'(s)); check("R9 set ignored", pinOut2, 4'h5);
      wr(5, 4'(s)); check("R9 clear ignored", pinOut2, 4'h5);
    end

    summary();
    $finish;
  end
endmodule